// File: doc/BRIEF.md
# Vector Compress and Expand Unit

This unit moves elements between two internal vector registers under the control of a per-element mask. In compress mode it walks the active elements of the source register, in index order, and packs every element whose mask bit is set into the destination starting at index 0. In expand mode it does the inverse: the low source elements are taken one after another and dropped into the destination indices whose mask bit is set. Both modes return the number of active set mask bits as the new packed vector length.

The caller fills the source register through a write port while the unit is idle, then pulses `start` with a mode, a mask and a vector length. The unit handles one element per clock and pulses `done` for a single cycle when the destination is complete. The destination is then read through a registered read port. Any destination index that the operation did not write reads back as zero.

Top module: `vec_compress_expand`

## Requirements
- R1: With `op` = 0 (compress), the source elements at active indices whose mask bit is 1 appear in the destination at indices 0, 1, 2, ... in ascending source order.
- R2: After a compress, every destination index at or above the packed length reads as zero.
- R3: With `op` = 1 (expand), source elements 0, 1, 2, ... are placed in ascending order into the active destination indices whose mask bit is 1.
- R4: After an expand, every active destination index whose mask bit is 0 reads as zero.
- R5: Only indices below the effective length take part, where the effective length is `vl` with values above 64 treated as 64; mask bits at or above it are ignored and destination indices at or above it read as zero.
- R6: `packed_len` equals the number of mask bits set below the effective length, for both modes, and holds that value from the cycle after `start` is accepted until the next accepted `start`.
- R7: Counting the edge that accepts `start` as edge 0, `done` is high for exactly the one cycle after edge VL+1 for an effective length VL of at least 1.
- R8: An effective length of 0 raises `done` in the cycle right after the accepting edge, with `packed_len` = 0 and the whole destination reading zero.
- R9: A `start` seen while an operation is in progress is ignored; a `start` in the cycle where `done` is high is accepted.
- R10: Source writes presented while an operation is in progress are ignored.
- R11: After reset `done` is low, `packed_len` is 0 and every destination index reads zero.
- R12: `dst_rdata` shows the destination element addressed by `dst_raddr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 1 | 0 = compress, 1 = expand |
| mask | input | 64 | Per-element mask, bit i controls index i |
| vl | input | 7 | Vector length; values above 64 act as 64 |
| src_we | input | 1 | Source register write enable |
| src_addr | input | 6 | Source register write index |
| src_wdata | input | 64 | Source register write data |
| dst_raddr | input | 6 | Destination register read index |
| dst_rdata | output | 64 | Destination element, one cycle after address |
| done | output | 1 | One-cycle completion pulse |
| packed_len | output | 7 | Population count of the active mask bits |

## Verification
The two functions that can meet in one cycle are completion and acceptance: the `done` cycle of one operation is also a cycle in which a new `start` is legal, and it is the moment the destination valid state is both finished and cleared. The bench provokes this by raising a second `start` in exactly the cycle it sees `done`, then judges the second result by its latency, its length and a full destination read against the model. It also drives a `start` and a source write in the middle of a run and expects the running result, its latency, and a later reuse of the untouched source element to be unchanged.

// File: rtl/vce_pkg.sv
package vce_pkg;
  typedef enum logic {
    OP_COMPRESS = 1'b0,
    OP_EXPAND   = 1'b1
  } vce_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } vce_state_e;
endpackage

// File: rtl/vce_ram.sv
module vce_ram #(
  parameter int W     = 64,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vce_popcount.sv
module vce_popcount #(
  parameter int N     = 64,
  localparam int CW   = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int j = 0; j < N; j++) count = count + CW'(bits[j]);
  end
endmodule

// File: rtl/vce_seq.sv
module vce_seq
  import vce_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  localparam int IDX_W   = $clog2(NUM_ELEM),
  localparam int LEN_W   = $clog2(NUM_ELEM + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                op,
  input  logic [NUM_ELEM-1:0] mask,
  input  logic [LEN_W-1:0]    vl_c,
  output logic                busy,
  output logic                launch,
  output logic [IDX_W-1:0]    src_raddr,
  output logic                dst_we,
  output logic [IDX_W-1:0]    dst_waddr,
  output logic                done,
  output logic [LEN_W-1:0]    packed_len
);
  vce_state_e          state;
  vce_op_e             op_q;
  logic [NUM_ELEM-1:0] mask_q;
  logic [LEN_W-1:0]    vl_q;
  logic [LEN_W-1:0]    idx;
  logic [LEN_W-1:0]    ptr;
  logic                wr_pend;
  logic [IDX_W-1:0]    wr_addr_q;
  logic [NUM_ELEM-1:0] active;
  logic [LEN_W-1:0]    active_cnt;
  logic                cur_bit;

  always_comb begin
    for (int j = 0; j < NUM_ELEM; j++) active[j] = mask[j] && (32'(vl_c) > j);
  end

  vce_popcount #(.N(NUM_ELEM)) i_pop (.bits(active), .count(active_cnt));

  assign busy      = (state != ST_IDLE);
  assign launch    = start && (state == ST_IDLE);
  assign cur_bit   = mask_q[idx[IDX_W-1:0]];
  assign src_raddr = (op_q == OP_EXPAND) ? ptr[IDX_W-1:0] : idx[IDX_W-1:0];
  assign dst_we    = wr_pend;
  assign dst_waddr = wr_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= OP_COMPRESS;
      mask_q     <= '0;
      vl_q       <= '0;
      idx        <= '0;
      ptr        <= '0;
      wr_pend    <= 1'b0;
      wr_addr_q  <= '0;
      done       <= 1'b0;
      packed_len <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          wr_pend <= 1'b0;
          if (start) begin
            op_q       <= vce_op_e'(op);
            mask_q     <= active;
            vl_q       <= vl_c;
            idx        <= '0;
            ptr        <= '0;
            packed_len <= active_cnt;
            if (vl_c == '0) done  <= 1'b1;
            else            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          wr_pend   <= cur_bit;
          wr_addr_q <= (op_q == OP_EXPAND) ? idx[IDX_W-1:0] : ptr[IDX_W-1:0];
          if (cur_bit) ptr <= ptr + LEN_W'(1);
          idx <= idx + LEN_W'(1);
          if ((idx + LEN_W'(1)) == vl_q) state <= ST_DRAIN;
        end
        default: begin
          wr_pend <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  // R1 R3: the packing pointer never runs ahead of the element index
  p_ptr_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (ptr <= idx));

  // R7: done is a single-cycle pulse unless a new zero-length start follows
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  // R9: a start during a run leaves the latched operation untouched
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_q) && $stable(vl_q) && $stable(mask_q)));

  // R8: zero length completes in the next cycle with no element written
  p_vl0_done_r8: assert property (@(posedge clk) disable iff (rst)
    (launch && vl_c == '0) |=> (done && packed_len == '0 && !busy));
endmodule

// File: rtl/vec_compress_expand.sv
module vec_compress_expand #(
  parameter int NUM_ELEM = 64,
  parameter int ELEM_W   = 64,
  localparam int IDX_W   = $clog2(NUM_ELEM),
  localparam int LEN_W   = $clog2(NUM_ELEM + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                op,
  input  logic [NUM_ELEM-1:0] mask,
  input  logic [LEN_W-1:0]    vl,
  input  logic                src_we,
  input  logic [IDX_W-1:0]    src_addr,
  input  logic [ELEM_W-1:0]   src_wdata,
  input  logic [IDX_W-1:0]    dst_raddr,
  output logic [ELEM_W-1:0]   dst_rdata,
  output logic                done,
  output logic [LEN_W-1:0]    packed_len
);
  logic [LEN_W-1:0]    vl_c;
  logic                busy;
  logic                launch;
  logic [IDX_W-1:0]    src_raddr;
  logic [ELEM_W-1:0]   src_rdata;
  logic                dst_we;
  logic [IDX_W-1:0]    dst_waddr;
  logic [ELEM_W-1:0]   dst_q;
  logic [NUM_ELEM-1:0] written;
  logic                written_q;

  assign vl_c = (vl > LEN_W'(NUM_ELEM)) ? LEN_W'(NUM_ELEM) : vl;

  vce_seq #(.NUM_ELEM(NUM_ELEM)) i_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .mask(mask), .vl_c(vl_c),
    .busy(busy), .launch(launch), .src_raddr(src_raddr),
    .dst_we(dst_we), .dst_waddr(dst_waddr),
    .done(done), .packed_len(packed_len)
  );

  vce_ram #(.W(ELEM_W), .DEPTH(NUM_ELEM)) i_src (
    .clk(clk), .we(src_we && !busy), .waddr(src_addr), .wdata(src_wdata),
    .raddr(src_raddr), .rdata(src_rdata)
  );

  vce_ram #(.W(ELEM_W), .DEPTH(NUM_ELEM)) i_dst (
    .clk(clk), .we(dst_we), .waddr(dst_waddr), .wdata(src_rdata),
    .raddr(dst_raddr), .rdata(dst_q)
  );

  // Per-element written flags: cleared in one cycle, so untouched entries read zero
  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
    end else begin
      if (launch)      written            <= '0;
      else if (dst_we) written[dst_waddr] <= 1'b1;
      written_q <= written[dst_raddr];
    end
  end

  assign dst_rdata = written_q ? dst_q : '0;

  // R10: no destination traffic while idle, so source edits cannot leak in
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !dst_we);

  // R6: the reported length never exceeds the effective length in use
  p_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
    launch |=> (packed_len <= $past(vl_c)));
endmodule

// File: tb/test_vec_compress_expand.sv
module test_vec_compress_expand;
  localparam int N  = 64;
  localparam int W  = 64;
  localparam int IW = 6;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          op = 1'b0;
  logic [N-1:0]  mask = '0;
  logic [LW-1:0] vl = '0;
  logic          src_we = 1'b0;
  logic [IW-1:0] src_addr = '0;
  logic [W-1:0]  src_wdata = '0;
  logic [IW-1:0] dst_raddr = '0;
  logic [W-1:0]  dst_rdata;
  logic          done;
  logic [LW-1:0] packed_len;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] src_m [N];
  logic [W-1:0] exp_d [N];
  string        exp_tag [N];
  int           exp_len;

  always #10 clk = ~clk;

  vec_compress_expand i_vec_compress_expand (
    .clk(clk), .rst(rst), .start(start), .op(op), .mask(mask), .vl(vl),
    .src_we(src_we), .src_addr(src_addr), .src_wdata(src_wdata),
    .dst_raddr(dst_raddr), .dst_rdata(dst_rdata),
    .done(done), .packed_len(packed_len)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  task automatic model(input bit o, input logic [N-1:0] m, input int v);
    int p = 0;
    int ve = (v > N) ? N : v;
    for (int i = 0; i < N; i++) begin
      exp_d[i] = '0;
      exp_tag[i] = (i >= ve) ? "R5" : (o ? "R4" : "R2");
    end
    for (int i = 0; i < ve; i++) begin
      if (m[i]) begin
        if (!o) begin exp_d[p] = src_m[i]; exp_tag[p] = "R1"; end
        else    begin exp_d[i] = src_m[p]; exp_tag[i] = "R3"; end
        p++;
      end
    end
    if (!o) for (int i = p; i < ve; i++) exp_tag[i] = "R2";
    exp_len = p;
  endtask

  task automatic write_src(input int a, input logic [W-1:0] d);
    @(negedge clk);
    src_we = 1'b1; src_addr = IW'(a); src_wdata = d;
    src_m[a] = d;
    @(negedge clk);
    src_we = 1'b0;
  endtask

  task automatic check_dst();
    dst_raddr = '0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      chk(dst_rdata == exp_d[i], exp_tag[i], $sformatf("dst[%0d] (R12 read)", i),
          dst_rdata, exp_d[i]);
      dst_raddr = IW'(i + 1);
    end
  endtask

  task automatic drive_start(input bit o, input logic [N-1:0] m, input int v);
    start = 1'b1; op = o; mask = m; vl = LW'(v);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int lat0, input int v);
    int lat = lat0;
    int ve = (v > N) ? N : v;
    int want = (ve == 0) ? 1 : ve + 2;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == want, (ve == 0) ? "R8" : "R7", "done latency", W'(lat), W'(want));
    chk(packed_len == LW'(exp_len), "R6", "packed_len", W'(packed_len), W'(exp_len));
  endtask

  task automatic run_op(input bit o, input logic [N-1:0] m, input int v);
    model(o, m, v);
    @(negedge clk);
    drive_start(o, m, v);
    wait_done(1, v);
    @(negedge clk);
    chk(!done, "R7", "done width", W'(done), 0);
    check_dst();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done, "R11", "done after reset", W'(done), 0);
    chk(packed_len == '0, "R11", "len after reset", W'(packed_len), 0);
    for (int i = 0; i < N; i++) begin exp_d[i] = '0; exp_tag[i] = "R11"; end
    check_dst();

    for (int i = 0; i < N; i++) write_src(i, {$urandom, $urandom});

    // directed corners
    run_op(1'b0, {N{1'b1}}, 64);            // R1 full compress
    run_op(1'b1, {N{1'b1}}, 64);            // R3 full expand
    run_op(1'b0, '0, 64);                   // R2 empty mask
    run_op(1'b1, 64'h8000_0000_0000_0001, 64);
    run_op(1'b0, 64'hAAAA_5555_F0F0_0F0F, 0);  // R8 zero length
    run_op(1'b1, 64'hFFFF_0000_FFFF_0001, 1);
    run_op(1'b0, {N{1'b1}}, 100);           // R5 clamp
    run_op(1'b1, {N{1'b1}}, 10);            // R5 mask above length ignored
    run_op(1'b0, 64'hFFFF_FFFF_FFFF_FC00, 10);

    // R9 R10: start and source write arriving mid-run
    model(1'b0, {N{1'b1}}, 20);
    @(negedge clk);
    drive_start(1'b0, {N{1'b1}}, 20);
    start = 1'b1; op = 1'b1; mask = '0; vl = 7'd5;
    src_we = 1'b1; src_addr = '0; src_wdata = 64'hDEAD_BEEF_0BAD_F00D;
    @(negedge clk);
    start = 1'b0; src_we = 1'b0;
    wait_done(2, 20);
    @(negedge clk);
    check_dst();
    run_op(1'b0, 64'h1, 1);                 // R10 source element 0 kept

    // R9: start accepted in the done cycle
    model(1'b1, 64'h0F0F_0F0F_0F0F_0F0F, 40);
    @(negedge clk);
    drive_start(1'b1, 64'h0F0F_0F0F_0F0F_0F0F, 40);
    wait_done(1, 40);
    model(1'b0, 64'h1234_5678_9ABC_DEF0, 33);
    drive_start(1'b0, 64'h1234_5678_9ABC_DEF0, 33);
    chk(!done, "R9", "done low after chained start", W'(done), 0);
    wait_done(1, 33);
    @(negedge clk);
    check_dst();

    // constrained random
    for (int k = 0; k < 24; k++) begin
      logic [N-1:0] m = {$urandom, $urandom};
      int v = $urandom_range(0, 70);
      if (k % 4 == 0) for (int i = 0; i < 4; i++) write_src($urandom_range(0, N - 1), {$urandom, $urandom});
      run_op(1'($urandom), m, v);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule